// File: doc/BRIEF.md
# Streaming Row-Serial Matrix Combiner

The block takes a stream of sample groups, five unsigned 8-bit values each. For every group it forms a 10x10 result matrix. Each result element is a weighted sum: every sample of the group multiplies the matching element of one of five fixed integer coefficient matrices, and the five products are added. The five coefficient matrices are built into the block as constants.

Ten multiply-accumulate lanes, one per column, do all the arithmetic. They are shared in time. A result row needs five cycles, one for each coefficient matrix, so a whole matrix takes fifty cycles. Each finished row is rounded to 12 bits per element and presented as one 120-bit beat with a valid/ready handshake. A second group can be captured while the current group is being computed, so groups stream back to back with no idle cycles.

A parameter selects how a group arrives. In parallel mode all five samples come in one beat. In serial mode one sample comes per beat, in order.

Top module: `matrow_combiner`

## Requirements
- R1: Each result element is Y[r][c] = sum over t=0..4 of x(t+1)*C(t)[r][c]. The coefficient is C(t)[r][c] = ((7t + 3r + 5c + t*r + r*c) mod 41) - 20, so every coefficient lies in -20..20. Samples are unsigned and the sum is exact in 16 signed bits.
- R2: Each output element is the 16-bit sum rounded by adding 8 and shifting right arithmetically by 4, then clipped to the signed 12-bit range -2048..2047. Element c occupies out_data bits [12c+11:12c].
- R3: The rows of one matrix leave in the order 0 to 9. out_row carries the row index, and out_last is 1 exactly when the row index is 9.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data, out_row and out_last hold their values.
- R5: In parallel mode a group is accepted on a clock edge where in_valid and in_ready are both 1. Sample x(k+1) is taken from in_data bits [8k+7:8k].
- R6: In serial mode each accepted beat carries one sample in in_data[7:0]. The beats arrive in the order x1, x2, x3, x4, x5, and five accepted beats make one group.
- R7: With out_ready held at 1 and input groups always available, consecutive rows leave exactly 5 cycles apart, including across the boundary between groups.
- R8: When out_ready is held at 0, the computation stops on the held row. in_ready falls to 0 once the capture buffer is full. After out_ready returns to 1, every accepted group still produces all ten rows.
- R9: Synchronous active-high reset clears out_valid and the internal valid flags. in_ready is 1 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | 40 (8 in serial mode) | Sample group, or a single sample in serial mode |
| out_valid | output | 1 | Output row valid |
| out_ready | input | 1 | Consumer takes the row |
| out_row | output | 4 | Index of the row on out_data |
| out_last | output | 1 | Row 9 of the matrix |
| out_data | output | 120 | Ten 12-bit signed result elements |

## Verification
The assertions check the handshake rules on every cycle. They confirm that a held row stays stable while the consumer stalls, that row indices step 0 through 9 and wrap, that the last-row flag matches index 9, and that reset clears the valid flags. The numeric result needs the bench's reference model, applied to table vectors and to corner samples such as all-zero, all-255 and single nonzero terms. The bench scenarios also cover the 5-cycle row spacing in back-to-back streaming, the filling of the capture buffer during a long consumer stall with no group lost, and serial sample arrival.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  // Integer coefficient for term t, row r, column c; range -20..20.
  function automatic int coef_val(input int t, input int r, input int c);
    return ((7 * t + 3 * r + 5 * c + t * r + r * c) % 41) - 20;
  endfunction
endpackage

// File: rtl/mrc_input_stage.sv
module mrc_input_stage #(
  parameter int TERMS     = 5,
  parameter int SAMPLE_W  = 8,
  parameter bit SERIAL_IN = 1'b0,
  localparam int GRP_W    = TERMS * SAMPLE_W,
  localparam int IN_W     = SERIAL_IN ? SAMPLE_W : GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  input  logic             take,
  output logic             grp_valid,
  output logic [GRP_W-1:0] grp
);
  assign in_ready = !grp_valid;

  generate
    if (SERIAL_IN) begin : g_serial
      localparam int IDX_W = (TERMS > 1) ? $clog2(TERMS) : 1;
      logic [IDX_W-1:0] slot;
      always_ff @(posedge clk) begin
        if (rst) begin
          slot      <= '0;
          grp_valid <= 1'b0;
          grp       <= '0;
        end else if (in_valid && !grp_valid) begin
          grp[slot*SAMPLE_W +: SAMPLE_W] <= in_data[SAMPLE_W-1:0];
          if (slot == IDX_W'(TERMS - 1)) begin
            slot      <= '0;
            grp_valid <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end else if (take) begin
          grp_valid <= 1'b0;
        end
      end
    end else begin : g_parallel
      always_ff @(posedge clk) begin
        if (rst) begin
          grp_valid <= 1'b0;
          grp       <= '0;
        end else if (in_valid && !grp_valid) begin
          grp       <= in_data;
          grp_valid <= 1'b1;
        end else if (take) begin
          grp_valid <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/mrc_coef_rom.sv
module mrc_coef_rom #(
  parameter int TERMS  = 5,
  parameter int ROWS   = 10,
  parameter int COLS   = 10,
  parameter int COEF_W = 8,
  localparam int TERM_W = (TERMS > 1) ? $clog2(TERMS) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TBL_W  = TERMS * ROWS * COLS * COEF_W
) (
  input  logic [TERM_W-1:0]       term,
  input  logic [ROW_W-1:0]        row,
  output logic [COLS*COEF_W-1:0]  coefs
);
  function automatic logic [TBL_W-1:0] build_table();
    logic [TBL_W-1:0] tbl;
    tbl = '0;
    for (int t = 0; t < TERMS; t++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          tbl[((t * ROWS + r) * COLS + c) * COEF_W +: COEF_W] =
            COEF_W'(mrc_pkg::coef_val(t, r, c));
    return tbl;
  endfunction

  localparam logic [TBL_W-1:0] TABLE = build_table();

  int base;
  always_comb begin
    base  = (int'(term) * ROWS + int'(row)) * COLS * COEF_W;
    coefs = TABLE[base +: COLS*COEF_W];
  end
endmodule

// File: rtl/mrc_mac_lane.sv
module mrc_mac_lane #(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int ACC_W    = 16,
  parameter int OUT_W    = 12,
  localparam int FRAC    = ACC_W - OUT_W,
  localparam int SH_W    = ACC_W - FRAC + 1,
  localparam int OMAX    = (1 <<< (OUT_W - 1)) - 1,
  localparam int OMIN    = -(1 <<< (OUT_W - 1))
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     first,
  input  logic [SAMPLE_W-1:0]      sample,
  input  logic signed [COEF_W-1:0] coef,
  output logic [OUT_W-1:0]         res
);
  logic signed [ACC_W-1:0] acc, s_ext, c_ext, prod, sum;
  logic signed [ACC_W:0]   rnd;
  logic signed [SH_W-1:0]  shf;

  assign s_ext = {{(ACC_W-SAMPLE_W){1'b0}}, sample};
  assign c_ext = {{(ACC_W-COEF_W){coef[COEF_W-1]}}, coef};
  assign prod  = s_ext * c_ext;
  assign sum   = (first ? '0 : acc) + prod;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= sum;
  end

  always_comb begin
    rnd = {sum[ACC_W-1], sum} + (ACC_W+1)'(1 <<< (FRAC - 1));
    shf = rnd[ACC_W:FRAC];
    if (shf > $signed(SH_W'(OMAX)))      res = OUT_W'(OMAX);
    else if (shf < $signed(SH_W'(OMIN))) res = OUT_W'(OMIN);
    else                                 res = shf[OUT_W-1:0];
  end
endmodule

// File: rtl/matrow_combiner.sv
module matrow_combiner #(
  parameter int TERMS     = 5,
  parameter int ROWS      = 10,
  parameter int COLS      = 10,
  parameter int SAMPLE_W  = 8,
  parameter int COEF_W    = 8,
  parameter int ACC_W     = 16,
  parameter int OUT_W     = 12,
  parameter bit SERIAL_IN = 1'b0,
  localparam int GRP_W    = TERMS * SAMPLE_W,
  localparam int IN_W     = SERIAL_IN ? SAMPLE_W : GRP_W,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TERM_W   = (TERMS > 1) ? $clog2(TERMS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [IN_W-1:0]       in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ROW_W-1:0]      out_row,
  output logic                  out_last,
  output logic [COLS*OUT_W-1:0] out_data
);
  localparam logic [TERM_W-1:0] TERM_LAST = TERM_W'(TERMS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  logic             grp_valid, take, busy, adv, row_done, mat_done;
  logic [GRP_W-1:0] grp, act;
  logic [TERM_W-1:0] term;
  logic [ROW_W-1:0]  row;
  logic [COLS*COEF_W-1:0] coefs;
  logic [COLS*OUT_W-1:0]  lane_res;
  logic [SAMPLE_W-1:0]    cur_sample;

  mrc_input_stage #(.TERMS(TERMS), .SAMPLE_W(SAMPLE_W), .SERIAL_IN(SERIAL_IN)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .take(take), .grp_valid(grp_valid), .grp(grp)
  );

  mrc_coef_rom #(.TERMS(TERMS), .ROWS(ROWS), .COLS(COLS), .COEF_W(COEF_W)) u_rom (
    .term(term), .row(row), .coefs(coefs)
  );

  assign row_done   = busy && (term == TERM_LAST);
  assign adv        = busy && !(row_done && out_valid && !out_ready);
  assign mat_done   = adv && row_done && (row == ROW_LAST);
  assign take       = grp_valid && (!busy || mat_done);
  assign cur_sample = act[term*SAMPLE_W +: SAMPLE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      term <= '0;
      row  <= '0;
      act  <= '0;
    end else begin
      if (take) act <= grp;
      if (!busy) begin
        if (take) begin
          busy <= 1'b1;
          term <= '0;
          row  <= '0;
        end
      end else if (adv) begin
        if (term == TERM_LAST) begin
          term <= '0;
          if (row == ROW_LAST) begin
            row  <= '0;
            busy <= take;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          term <= term + 1'b1;
        end
      end
    end
  end

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_lane
      mrc_mac_lane #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_lane (
        .clk(clk), .rst(rst), .en(adv), .first(term == '0),
        .sample(cur_sample), .coef($signed(coefs[c*COEF_W +: COEF_W])),
        .res(lane_res[c*OUT_W +: OUT_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else if (adv && row_done) begin
      out_valid <= 1'b1;
      out_row   <= row;
      out_last  <= (row == ROW_LAST);
      out_data  <= lane_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int ROWS  = 10,
  parameter int COLS  = 10,
  parameter int OUT_W = 12,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [ROW_W-1:0]      out_row,
  input logic                  out_last,
  input logic [COLS*OUT_W-1:0] out_data
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_row) && $stable(out_last)); // R4

  AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid ||
      out_row == (($past(out_row) == ROW_W'(ROWS - 1)) ? '0 : $past(out_row) + 1'b1)); // R3

  AST_LAST_FLAG: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_last == (out_row == ROW_W'(ROWS - 1))); // R3

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_row < ROW_W'(ROWS)); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready); // R9
endmodule

bind matrow_combiner mrc_checker #(.ROWS(ROWS), .COLS(COLS), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/matrow_combiner_bench.sv
module matrow_combiner_bench;
  localparam int NV = 8;
  // Group vectors: x1 in bits [7:0] ... x5 in bits [39:32] (R5)
  localparam logic [39:0] VEC [NV] = '{
    40'h00_00_00_00_00, 40'hFF_FF_FF_FF_FF, 40'h00_00_01_00_00, 40'h00_00_00_00_80,
    40'h12_34_56_78_9A, 40'hFF_00_FF_00_FF, 40'h01_02_03_04_05, 40'h80_7F_10_F0_33};

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic in_valid_a = 0, in_ready_a, out_valid_a, out_ready_a = 1, out_last_a;
  logic [39:0] in_data_a = '0;
  logic [3:0] out_row_a;
  logic [119:0] out_data_a;
  logic in_valid_b = 0, in_ready_b, out_valid_b, out_ready_b = 1, out_last_b;
  logic [7:0] in_data_b = '0;
  logic [3:0] out_row_b;
  logic [119:0] out_data_b;

  matrow_combiner u_matrow_combiner (
    .clk(clk), .rst(rst), .in_valid(in_valid_a), .in_ready(in_ready_a), .in_data(in_data_a),
    .out_valid(out_valid_a), .out_ready(out_ready_a), .out_row(out_row_a),
    .out_last(out_last_a), .out_data(out_data_a));

  matrow_combiner #(.SERIAL_IN(1'b1)) u_matrow_combiner_ser (
    .clk(clk), .rst(rst), .in_valid(in_valid_b), .in_ready(in_ready_b), .in_data(in_data_b),
    .out_valid(out_valid_b), .out_ready(out_ready_b), .out_row(out_row_b),
    .out_last(out_last_b), .out_data(out_data_b));

  int tests = 0, fails = 0, cyc = 0;
  int rows_a = 0, rows_b = 0, n_acc_a = 0, n_acc_b = 0, last_cyc = 0;
  bit gap_on = 0, have_last = 0, done = 0, prev_stall = 0;
  logic [119:0] prev_data;
  logic [39:0] acc_a [32];
  logic [39:0] acc_b [8];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [119:0] exp_row(input logic [39:0] g, input int r);
    logic [119:0] res;
    for (int c = 0; c < 10; c++) begin
      int s = 0;
      for (int t = 0; t < 5; t++)
        s += int'(g[8*t +: 8]) * (((7*t + 3*r + 5*c + t*r + r*c) % 41) - 20);
      s = (s + 8) >>> 4;
      if (s > 2047) s = 2047;
      if (s < -2048) s = -2048;
      res[12*c +: 12] = s[11:0];
    end
    return res;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (prev_stall)  // R4
        chk(out_valid_a && out_data_a == prev_data, "R4 held row", {7'd0, out_valid_a, out_data_a}, {8'd1, prev_data});
      prev_stall = out_valid_a && !out_ready_a;
      prev_data  = out_data_a;
      if (out_valid_a && out_ready_a) begin
        chk(out_data_a == exp_row(acc_a[rows_a / 10], rows_a % 10), "R1 R2 R5 row data",
            out_data_a, exp_row(acc_a[rows_a / 10], rows_a % 10));
        chk(out_row_a == 4'(rows_a % 10) && out_last_a == (rows_a % 10 == 9), "R3 row index/last",
            {out_last_a, out_row_a}, {(rows_a % 10 == 9), 4'(rows_a % 10)});
        if (gap_on && have_last)
          chk(cyc - last_cyc == 5, "R7 row spacing", cyc - last_cyc, 5);
        have_last = 1; last_cyc = cyc; rows_a++;
      end
      if (out_valid_b && out_ready_b) begin
        chk(out_data_b == exp_row(acc_b[rows_b / 10], rows_b % 10), "R6 serial row data",
            out_data_b, exp_row(acc_b[rows_b / 10], rows_b % 10));
        chk(out_row_b == 4'(rows_b % 10), "R6 R3 serial row index", out_row_b, rows_b % 10);
        rows_b++;
      end
    end
  end

  task automatic send_a(input logic [39:0] g);
    @(negedge clk); in_valid_a = 1; in_data_a = g;
    while (!in_ready_a) @(negedge clk);
    @(posedge clk); acc_a[n_acc_a] = g; n_acc_a++;
    #1 in_valid_a = 0;
  endtask

  task automatic send_b(input logic [39:0] g);
    acc_b[n_acc_b] = g; n_acc_b++;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); in_valid_b = 1; in_data_b = g[8*k +: 8];
      while (!in_ready_b) @(negedge clk);
      @(posedge clk); #1 in_valid_b = 0;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!out_valid_a && !out_valid_b, "R9 out_valid after reset", {out_valid_a, out_valid_b}, 0);
    chk(in_ready_a && in_ready_b, "R9 in_ready after reset", {in_ready_a, in_ready_b}, 2'b11);

    gap_on = 1;
    for (int i = 0; i < NV; i++) send_a(VEC[i]);
    for (int w = 0; w < 1000 && rows_a < NV*10; w++) @(negedge clk);
    gap_on = 0;

    fork
      for (int i = 0; i < 4; i++) send_a(40'(i * 40'h1F_3B_57_71_93 + 40'h05_A0_0F_C3_3C));
      begin
        repeat (20) @(negedge clk);
        out_ready_a = 0;
        repeat (150) @(negedge clk);
        chk(!in_ready_a, "R8 in_ready low during stall", in_ready_a, 0);
        chk(out_valid_a, "R8 row held during stall", out_valid_a, 1);
        out_ready_a = 1;
      end
    join
    for (int w = 0; w < 2000 && rows_a < (NV+4)*10; w++) @(negedge clk);
    chk(rows_a == (NV+4)*10, "R8 no rows lost", rows_a, (NV+4)*10);

    send_b(40'hFF_FF_FF_FF_FF);
    send_b(40'h01_00_00_00_00);
    send_b(40'h9C_3A_00_E1_47);
    for (int w = 0; w < 1000 && rows_b < 30; w++) @(negedge clk);
    chk(rows_b == 30, "R6 serial row count", rows_b, 30);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end
endmodule